// File: doc/BRIEF.md
# Set-Bit Stream Encoder

The block takes a wide bitmask, one bit per rule, and lists the position of every bit that is set. Positions come out one per clock cycle in strictly ascending order, so bit 0 has the highest priority. A classic priority encoder reports only the winner. This block reports the winner and then all the others behind it, so a downstream stage can work through every candidate rule of a packet.

The structure is a registered binary tree. The mask bits are the leaves, and every inner node holds at most one pending entry. In each cycle an empty node, or a node whose entry its parent is taking, pulls an entry from one child. It prefers the lower-index child. The chosen entry is cleared from the child, and the node records which child it came from as one more index bit. After log2(N) levels the root holds a complete index and presents it on the output. Once the pipeline is full, entries stream out with no gaps.

A load strobe captures a new mask, but only while the block reports done. Done falls after an accepted load and rises again once the last index has been shown.

Top module: `setbit_stream_enc`

## Requirements
- R1: After reset, outValid is 0 and done is 1.
- R2: The indices of one mask appear in strictly ascending order. Each set bit appears exactly once, and no clear bit appears.
- R3: When a load is accepted at clock edge e, the first index is on the output after edge e + log2(NUM_IN), and not before.
- R4: For a mask with P set bits, outValid is 1 for exactly P consecutive cycles, with no gap.
- R5: Done is 0 from the edge that accepts a load until the edge after the final index. It is 1 in the first cycle after the last valid index. outValid is never 1 while done is 1.
- R6: An all-zero mask never raises outValid. Done is 0 for exactly one cycle after the accepting edge.
- R7: A load presented while done is 0 is ignored. The stream in progress continues unchanged, and done does not fall again.
- R8: The index reported for mask bit i is the binary value i, with bit 0 of mask giving index 0.
- R9: An all-ones mask yields every index from 0 to NUM_IN-1 in NUM_IN consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture mask on this edge (accepted only while done) |
| mask | input | NUM_IN | Bitmask to be listed |
| outValid | output | 1 | outIdx carries a listed index |
| outIdx | output | log2(NUM_IN) | Position of a set mask bit |
| done | output | 1 | No entry left in flight; ready for a load |

## Verification
The bench checks every cycle of each run against a timeline computed from the mask: when valid must rise and fall, which index appears in each slot, and the exact cycle done returns. It targets the full mask, which would expose a bubble or a lost entry where two subtrees meet. It also targets single-bit masks at the top and bottom positions, where a wrong index bit or a miscounted latency shows at once. An all-zero mask would hang a design that waits for a final index. A reload during a stream would corrupt the output of a design that lets a busy load through. Random masks of mixed density catch ordering errors, where a right child wins while its left sibling still waits.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sbeState_t;

  typedef struct packed {
    logic loadLeaves;
  } sbeStrobes_t;

endpackage

// File: rtl/sbe_ctrl.sv
module sbe_ctrl
  import sbe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        load,
  input  logic        treeEmpty,
  input  logic        lastOut,
  output sbeStrobes_t strb,
  output logic        done
);

  sbeState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (load) stateNext = ST_RUN;
      ST_RUN:  if (treeEmpty || lastOut) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb            = '0;
    strb.loadLeaves = load && (state == ST_IDLE);
  end

  assign done = (state == ST_IDLE);

  AST_EMPTY_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && treeEmpty) |=> done); // R6

endmodule

// File: rtl/sbe_node.sv
module sbe_node #(
  parameter int IDX_W = 6,
  parameter int LEVEL = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             leftVld,
  input  logic [IDX_W-1:0] leftIdx,
  input  logic             rightVld,
  input  logic [IDX_W-1:0] rightIdx,
  input  logic             parentTake,
  output logic             leftTake,
  output logic             rightTake,
  output logic             nodeVld,
  output logic [IDX_W-1:0] nodeIdx
);

  logic             accept;
  logic [IDX_W-1:0] idxNext;

  // A slot frees up when empty or when the parent drains it this cycle.
  assign accept    = !nodeVld || parentTake;
  assign leftTake  = accept && leftVld;
  assign rightTake = accept && !leftVld && rightVld;

  always_comb begin
    idxNext            = leftVld ? leftIdx : rightIdx;
    idxNext[LEVEL-1]   = !leftVld;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nodeVld <= 1'b0;
      nodeIdx <= '0;
    end else if (accept) begin
      nodeVld <= leftVld || rightVld;
      nodeIdx <= idxNext;
    end
  end

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (nodeVld && !parentTake) |=> (nodeVld && $stable(nodeIdx))); // R4

endmodule

// File: rtl/sbe_tree.sv
module sbe_tree
  import sbe_pkg::*;
#(
  parameter  int NUM_IN = 64,
  localparam int IDX_W  = $clog2(NUM_IN),
  localparam int LEVELS = IDX_W,
  localparam int INNER  = NUM_IN - 1,
  localparam int ROOT   = NUM_IN - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbeStrobes_t       strb,
  input  logic [NUM_IN-1:0] mask,
  output logic              outValid,
  output logic [IDX_W-1:0]  outIdx,
  output logic              treeEmpty,
  output logic              lastOut
);

  localparam logic [IDX_W-1:0] LEAF_IDX = '0;

  logic [NUM_IN-1:0] leafVec;
  logic              leafTake  [NUM_IN];
  logic              innerVld  [INNER];
  logic [IDX_W-1:0]  innerIdx  [INNER];
  logic              innerTake [INNER];
  logic              anyBelow;

  // Leaf layer: filled by a load, each bit cleared when its parent picks it.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      leafVec <= '0;
    end else if (strb.loadLeaves) begin
      leafVec <= mask;
    end else begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (leafTake[i]) leafVec[i] <= 1'b0;
      end
    end
  end

  // Inner nodes stored level by level; level k starts at NUM_IN - 2*(NUM_IN>>k).
  for (genvar k = 1; k <= LEVELS; k++) begin : g_lvl
    localparam int BASE  = NUM_IN - 2 * (NUM_IN >> k);
    localparam int CBASE = NUM_IN - 2 * (NUM_IN >> (k - 1));
    for (genvar j = 0; j < (NUM_IN >> k); j++) begin : g_node
      if (k == 1) begin : g_leafKids
        sbe_node #(.IDX_W(IDX_W), .LEVEL(k)) i_node (
          .clk       (clk),
          .rstN      (rstN),
          .leftVld   (leafVec[2*j]),
          .leftIdx   (LEAF_IDX),
          .rightVld  (leafVec[2*j+1]),
          .rightIdx  (LEAF_IDX),
          .parentTake(innerTake[BASE+j]),
          .leftTake  (leafTake[2*j]),
          .rightTake (leafTake[2*j+1]),
          .nodeVld   (innerVld[BASE+j]),
          .nodeIdx   (innerIdx[BASE+j])
        );
      end else begin : g_innerKids
        sbe_node #(.IDX_W(IDX_W), .LEVEL(k)) i_node (
          .clk       (clk),
          .rstN      (rstN),
          .leftVld   (innerVld[CBASE+2*j]),
          .leftIdx   (innerIdx[CBASE+2*j]),
          .rightVld  (innerVld[CBASE+2*j+1]),
          .rightIdx  (innerIdx[CBASE+2*j+1]),
          .parentTake(innerTake[BASE+j]),
          .leftTake  (innerTake[CBASE+2*j]),
          .rightTake (innerTake[CBASE+2*j+1]),
          .nodeVld   (innerVld[BASE+j]),
          .nodeIdx   (innerIdx[BASE+j])
        );
      end
    end
  end

  // The root drains every cycle: there is no back-pressure on the output.
  assign innerTake[ROOT] = innerVld[ROOT];

  always_comb begin
    anyBelow = |leafVec;
    for (int n = 0; n < ROOT; n++) begin
      anyBelow = anyBelow || innerVld[n];
    end
  end

  assign outValid  = innerVld[ROOT];
  assign outIdx    = innerIdx[ROOT];
  assign treeEmpty = !innerVld[ROOT] && !anyBelow;
  assign lastOut   = innerVld[ROOT] && !anyBelow;

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> (outIdx > $past(outIdx))); // R2

  AST_NO_NEW_LEAF: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadLeaves |=> ((leafVec & ~$past(leafVec)) == '0)); // R7

endmodule

// File: rtl/setbit_stream_enc.sv
module setbit_stream_enc
  import sbe_pkg::*;
#(
  parameter  int NUM_IN = 64,
  localparam int IDX_W  = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [NUM_IN-1:0] mask,
  output logic              outValid,
  output logic [IDX_W-1:0]  outIdx,
  output logic              done
);

  sbeStrobes_t strb;
  logic        treeEmpty;
  logic        lastOut;

  sbe_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .load     (load),
    .treeEmpty(treeEmpty),
    .lastOut  (lastOut),
    .strb     (strb),
    .done     (done)
  );

  sbe_tree #(.NUM_IN(NUM_IN)) i_tree (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .mask     (mask),
    .outValid (outValid),
    .outIdx   (outIdx),
    .treeEmpty(treeEmpty),
    .lastOut  (lastOut)
  );

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid); // R5

  AST_DONE_FALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> $past(load)); // R7

endmodule

// File: tb/test_setbit_stream_enc.sv
module test_setbit_stream_enc;

  localparam int N = 64;
  localparam int L = 6;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         load = 1'b0;
  logic [N-1:0] mask = '0;
  logic         outValid;
  logic [L-1:0] outIdx;
  logic         done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  setbit_stream_enc i_setbit_stream_enc (
    .clk     (clk),
    .rstN    (rstN),
    .load    (load),
    .mask    (mask),
    .outValid(outValid),
    .outIdx  (outIdx),
    .done    (done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int popCount(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) if (m[i]) c++;
    return c;
  endfunction

  function automatic int nthSet(input logic [N-1:0] m, input int n);
    int seen = 0;
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin
        if (seen == n) return i;
        seen++;
      end
    end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string tag,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, tag, act, exp);
    end
  endtask

  // Load m, then check every cycle against the expected timeline.
  task automatic runMask(input logic [N-1:0] m, input int busyAt, input string tag);
    int p = popCount(m);
    bit expV, expD;
    @(negedge clk);
    load = 1'b1;
    mask = m;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    mask = {$urandom, $urandom};
    for (int t = 0; t <= L + p + 1; t++) begin
      expV = (p > 0) && (t >= L) && (t < L + p);
      expD = (p == 0) ? (t >= 1) : (t >= L + p);
      chk(outValid == expV, "R3 R4 valid", tag, outValid, expV);
      if (expV && outValid)
        chk(outIdx == L'(nthSet(m, t - L)), "R2 R8 index", tag, outIdx, nthSet(m, t - L));
      chk(done == expD, "R5 done", tag, done, expD);
      if (t == busyAt) begin
        load = 1'b1;
        mask = ~m;
      end else begin
        load = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    load = 1'b0;
  endtask

  initial begin
    logic [N-1:0] r;
    int kind;
    int p;
    void'($urandom(32'h1234_abcd));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outValid == 1'b0, "R1 reset valid", "reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(done == 1'b1, "R1 reset done", "reset", done, 1);
    chk(outValid == 1'b0, "R1 idle valid", "reset", outValid, 0);

    runMask('0, -1, "R6 zero mask");
    runMask({N{1'b1}}, -1, "R9 full mask");
    runMask(64'h1, -1, "R8 bit0");
    runMask(64'h8000_0000_0000_0000, -1, "R8 bit63");
    runMask(64'h0000_0020_0000_0000, -1, "R8 bit37");
    runMask(64'hAAAA_AAAA_AAAA_AAAA, -1, "R2 odd bits");
    runMask(64'h8000_0000_0000_0001, 3, "R7 busy load");
    runMask({N{1'b1}}, 40, "R7 busy load full");
    runMask('0, -1, "R6 zero again");

    for (int run = 0; run < 150; run++) begin
      kind = $urandom_range(0, 3);
      r = {$urandom, $urandom};
      case (kind)
        0: r = r & {$urandom, $urandom} & {$urandom, $urandom};
        1: r = r | {$urandom, $urandom};
        2: r = r & {$urandom, $urandom};
        default: r = r;
      endcase
      p = popCount(r);
      if (p > 0 && (run % 3) == 0)
        runMask(r, $urandom_range(0, L + p - 1), "R7 random busy");
      else
        runMask(r, -1, "R2 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule